// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central interlock of a small out-of-order issue core. It tracks instructions as they pass through four steps: issue, operand read, execution complete and result write. Five functional units are attached: an integer/load unit, two multipliers, an adder and a divider. One decoded instruction is presented per cycle as an operation class, a destination register and two source registers. The unit accepts it only when the structural and output-dependence conditions allow. Held instructions block everything behind them, so issue stays in program order.

Each unit has a status entry: busy flag, class, destination, both sources, the identity of the unit producing each source, and a ready flag per source. A table indexed by register holds the unit that will write that register. A unit starts executing, out of program order, as soon as both of its sources are ready. Internal latency counters stand in for the execution pipelines. A finished unit may write its result only once no other unit still has to read the old value of that register. The write then frees the unit and wakes every waiter.

Top module: `sb_scoreboard`

## Requirements
- R1: `issue_ok` is high exactly when `in_valid` is high, the target unit is not busy, and no busy unit has `in_dst` as its destination. When `issue_ok` is low, the offered instruction is not taken.
- R2: Class codes map to units as follows: 0 goes to unit 1 (integer), 1 goes to unit 2 or, when unit 2 is busy, unit 3 (multipliers), 2 goes to unit 4 (adder) and 3 goes to unit 5 (divider). Bit u-1 of every per-unit vector belongs to unit u. At most one instruction is accepted per clock.
- R3: After synchronous reset, no unit is busy, no register has a pending writer, and `fu_start`, `fu_done` and `wb_en` are all zero.
- R4: `fu_start` of a busy unit pulses for exactly one cycle. The pulse comes in the first cycle in which neither source waits on a producing unit. It may come ahead of older instructions.
- R5: A source whose producer writes back in the same cycle that the consumer issues counts as ready. The consumer can start in the next cycle.
- R6: A unit started in cycle t raises `fu_done` in cycle t+LAT+1 and holds it until its write-back. LAT is the unit's latency parameter.
- R7: A finished unit's write-back is withheld while any other busy unit has a ready but unread source equal to its destination. This includes a unit that reads in that same cycle.
- R8: At most one unit writes back per cycle. Among finished units that pass the R7 check, the lowest-numbered one wins. `wb_dst` carries its destination.
- R9: A write-back frees the unit and clears the pending-writer entry of its destination. It also marks ready every source waiting on that unit, so those consumers may start in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is offered |
| in_class | input | 2 | Operation class (R2 encoding) |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| issue_ok | output | 1 | Offered instruction is accepted this cycle |
| fu_busy | output | 5 | Busy flag per unit |
| fu_start | output | 5 | Operand read and execution start per unit |
| fu_done | output | 5 | Execution complete per unit |
| wb_en | output | 5 | Register-file write enable per unit |
| wb_dst | output | 5 | Register written this cycle |

## Verification
Assertions check the following on every cycle: a single write-back winner, a write only from a finished unit, one-cycle start pulses, a pending writer recorded behind every accepted issue, and latency counters that are never restarted while running. The rest needs the bench's cycle model, which tracks the tables from the observed events: the order in which stalled issue, delayed operand read and withheld write-back interact, and the exact cycle of each start and completion. The directed sequences add three cases that random traffic reaches only rarely: a write-back held back by an unread older source, a wake-up during the same cycle as an issue, and the choice of the second multiplier.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NUM_FU  = 5;
    localparam int FU_W    = 3;
    localparam int REG_W   = 5;
    localparam int NUM_REG = 1 << REG_W;

    typedef enum logic [1:0] {
        CL_INT = 2'd0,
        CL_MUL = 2'd1,
        CL_ADD = 2'd2,
        CL_DIV = 2'd3
    } op_class_e;

    typedef struct packed {
        logic             busy;
        logic [1:0]       op;
        logic [REG_W-1:0] fi;
        logic [REG_W-1:0] fj;
        logic [REG_W-1:0] fk;
        logic [FU_W-1:0]  qj;
        logic [FU_W-1:0]  qk;
        logic             rj;
        logic             rk;
    } fu_entry_t;

    // table index (unit id minus one) chosen for a class
    function automatic logic [FU_W-1:0] class_slot(input logic [1:0] cls,
                                                   input logic mul_a_busy);
        case (cls)
            CL_INT:  class_slot = FU_W'(0);
            CL_MUL:  class_slot = mul_a_busy ? FU_W'(2) : FU_W'(1);
            CL_ADD:  class_slot = FU_W'(3);
            default: class_slot = FU_W'(4);
        endcase
    endfunction
endpackage

// File: rtl/sb_fu_timer.sv
module sb_fu_timer #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic clear_i,
    output logic done_o
);
    localparam int CNT_W = $clog2(LAT + 1) + 1;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start_i) begin
            t_d.run = 1'b1;
            t_d.cnt = CNT_W'(LAT);
        end else if (t_q.run) begin
            if (t_q.cnt <= CNT_W'(1)) begin
                t_d.run  = 1'b0;
                t_d.done = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt - CNT_W'(1);
            end
        end
        if (clear_i) t_d.done = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign done_o = t_q.done;

    // R6: a unit is never restarted while it executes or holds a finished result
    assert_timer_idle_R6: assert property (@(posedge clk) disable iff (rst)
        start_i |-> (!t_q.run && !t_q.done))
        else $error("timer restarted while active");
endmodule

// File: rtl/sb_war_check.sv
module sb_war_check
    import sb_pkg::*;
(
    input  fu_entry_t [NUM_FU-1:0] ents_i,
    output logic      [NUM_FU-1:0] ok_o
);
    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            ok_o[u] = 1'b1;
            for (int v = 0; v < NUM_FU; v++) begin
                if (v != u && ents_i[v].busy) begin
                    if ((ents_i[v].fj == ents_i[u].fi && ents_i[v].rj) ||
                        (ents_i[v].fk == ents_i[u].fi && ents_i[v].rk))
                        ok_o[u] = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb
    import sb_pkg::*;
(
    input  logic [NUM_FU-1:0] req_i,
    output logic [NUM_FU-1:0] gnt_o,
    output logic [FU_W-1:0]   id_o
);
    always_comb begin
        gnt_o = '0;
        id_o  = '0;
        for (int i = NUM_FU - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o    = '0;
                gnt_o[i] = 1'b1;
                id_o     = FU_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
    import sb_pkg::*;
#(
    parameter int LAT_INT = 1,
    parameter int LAT_MUL = 10,
    parameter int LAT_ADD = 2,
    parameter int LAT_DIV = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_class,
    input  logic [REG_W-1:0]  in_dst,
    input  logic [REG_W-1:0]  in_src1,
    input  logic [REG_W-1:0]  in_src2,
    output logic              issue_ok,
    output logic [NUM_FU-1:0] fu_busy,
    output logic [NUM_FU-1:0] fu_start,
    output logic [NUM_FU-1:0] fu_done,
    output logic [NUM_FU-1:0] wb_en,
    output logic [REG_W-1:0]  wb_dst
);
    typedef struct packed {
        fu_entry_t [NUM_FU-1:0]            fu;
        logic [NUM_REG-1:0][FU_W-1:0]      rrs;
    } sb_state_t;

    sb_state_t st_d, st_q;

    logic [FU_W-1:0]   tgt_idx;
    logic [FU_W-1:0]   tgt_id;
    logic [FU_W-1:0]   qa, qb;
    logic [NUM_FU-1:0] war_ok;
    logic [NUM_FU-1:0] wb_req;
    logic [NUM_FU-1:0] wb_gnt;
    logic [FU_W-1:0]   wb_id;

    // ---------------- per-unit status views
    always_comb begin
        for (int i = 0; i < NUM_FU; i++) begin
            fu_busy[i]  = st_q.fu[i].busy;
            fu_start[i] = st_q.fu[i].busy && st_q.fu[i].rj && st_q.fu[i].rk;
        end
    end

    // ---------------- execution latency models
    for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
        localparam int L = (g == 0) ? LAT_INT :
                           (g <= 2) ? LAT_MUL :
                           (g == 3) ? LAT_ADD : LAT_DIV;
        sb_fu_timer #(.LAT(L)) timer_i (
            .clk     (clk),
            .rst     (rst),
            .start_i (fu_start[g]),
            .clear_i (wb_gnt[g]),
            .done_o  (fu_done[g])
        );
    end

    // ---------------- write-back selection
    sb_war_check war_i (
        .ents_i (st_q.fu),
        .ok_o   (war_ok)
    );

    assign wb_req = fu_busy & fu_done & war_ok;

    sb_wb_arb arb_i (
        .req_i (wb_req),
        .gnt_o (wb_gnt),
        .id_o  (wb_id)
    );

    assign wb_en = wb_gnt;

    always_comb begin
        wb_dst = '0;
        for (int i = 0; i < NUM_FU; i++)
            if (wb_gnt[i]) wb_dst = st_q.fu[i].fi;
    end

    // ---------------- issue decision
    always_comb begin
        tgt_idx  = class_slot(in_class, st_q.fu[1].busy);
        tgt_id   = tgt_idx + FU_W'(1);
        issue_ok = in_valid && !st_q.fu[tgt_idx].busy && (st_q.rrs[in_dst] == '0);
        qa = st_q.rrs[in_src1];
        qb = st_q.rrs[in_src2];
        if (qa == wb_id) qa = '0;
        if (qb == wb_id) qb = '0;
    end

    // ---------------- next state
    always_comb begin
        st_d = st_q;
        // write result: free unit, clear pending writer
        for (int i = 0; i < NUM_FU; i++) begin
            if (wb_gnt[i]) begin
                st_d.rrs[st_q.fu[i].fi] = '0;
                st_d.fu[i]              = '0;
            end
        end
        // wake waiters, consume read operands
        for (int v = 0; v < NUM_FU; v++) begin
            if (wb_id != '0 && st_q.fu[v].busy && st_q.fu[v].qj == wb_id) begin
                st_d.fu[v].qj = '0;
                st_d.fu[v].rj = 1'b1;
            end
            if (wb_id != '0 && st_q.fu[v].busy && st_q.fu[v].qk == wb_id) begin
                st_d.fu[v].qk = '0;
                st_d.fu[v].rk = 1'b1;
            end
            if (fu_start[v]) begin
                st_d.fu[v].rj = 1'b0;
                st_d.fu[v].rk = 1'b0;
            end
        end
        // issue into the target entry
        if (issue_ok) begin
            st_d.fu[tgt_idx] = '{busy: 1'b1, op: in_class, fi: in_dst,
                                 fj: in_src1, fk: in_src2,
                                 qj: qa, qk: qb,
                                 rj: (qa == '0), rk: (qb == '0)};
            st_d.rrs[in_dst] = tgt_id;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // ---------------- assertions
    assert_one_writer_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wb_en))
        else $error("more than one write-back in a cycle");

    assert_wb_after_done_R7: assert property (@(posedge clk) disable iff (rst)
        (|wb_en) |-> ((wb_en & fu_done) == wb_en))
        else $error("write-back from unfinished unit");

    assert_pending_marked_R1: assert property (@(posedge clk) disable iff (rst)
        issue_ok |=> (st_q.rrs[$past(in_dst)] != '0))
        else $error("issued destination has no pending writer");

    for (genvar g = 0; g < NUM_FU; g++) begin : g_chk
        assert_start_once_R4: assert property (@(posedge clk) disable iff (rst)
            fu_start[g] |=> !fu_start[g])
            else $error("start pulse longer than one cycle");
    end
endmodule

// File: tb/sb_scoreboard_tb_top.sv
module sb_scoreboard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int L_INT = 1;
    localparam int L_MUL = 10;
    localparam int L_ADD = 2;
    localparam int L_DIV = 40;
    localparam int NF = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [1:0] in_class = '0;
    logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic       issue_ok;
    logic [4:0] fu_busy, fu_start, fu_done, wb_en, wb_dst;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // bench-side tables
    int m_busy[NF], m_fi[NF], m_fj[NF], m_fk[NF], m_qj[NF], m_qk[NF];
    int m_rj[NF], m_rk[NF], m_run[NF], m_t0[NF];
    int m_rrs[32];

    sb_scoreboard #(.LAT_INT(L_INT), .LAT_MUL(L_MUL), .LAT_ADD(L_ADD), .LAT_DIV(L_DIV)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .issue_ok(issue_ok), .fu_busy(fu_busy), .fu_start(fu_start),
        .fu_done(fu_done), .wb_en(wb_en), .wb_dst(wb_dst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int lat_of(input int i);
        if (i == 0) return L_INT;
        if (i <= 2) return L_MUL;
        if (i == 3) return L_ADD;
        return L_DIV;
    endfunction

    function automatic int slot_of(input int cls);
        if (cls == 0) return 0;
        if (cls == 1) return (m_busy[1] != 0) ? 2 : 1;
        if (cls == 2) return 3;
        return 4;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // one clock: drive, compare against tables, advance tables
    task automatic step(input bit v, input int cls, input int dst, input int s1,
                        input int s2, output bit iss);
        int tgt, w, e_iss, e_start, e_done, e_wb, e_dst;
        bit ok;
        in_valid = v; in_class = 2'(cls); in_dst = 5'(dst);
        in_src1 = 5'(s1); in_src2 = 5'(s2);
        #1;
        tgt   = slot_of(cls);
        e_iss = (v && m_busy[tgt] == 0 && m_rrs[dst] == 0) ? 1 : 0;
        check("R1 issue_ok", issue_ok, e_iss);
        e_start = 0; e_done = 0;
        for (int i = 0; i < NF; i++) begin
            if (m_busy[i] != 0 && m_rj[i] != 0 && m_rk[i] != 0) e_start |= (1 << i);
            if (m_run[i] != 0 && (cyc - m_t0[i]) >= lat_of(i) + 1) e_done |= (1 << i);
        end
        check("R4 fu_start", fu_start, e_start);
        check("R6 fu_done", fu_done, e_done);
        w = -1;
        for (int u = NF - 1; u >= 0; u--) begin
            ok = (m_busy[u] != 0) && ((e_done >> u) & 1);
            for (int q = 0; q < NF; q++)
                if (q != u && m_busy[q] != 0 &&
                    ((m_fj[q] == m_fi[u] && m_rj[q] != 0) || (m_fk[q] == m_fi[u] && m_rk[q] != 0)))
                    ok = 0;
            if (ok) w = u;
        end
        e_wb  = (w >= 0) ? (1 << w) : 0;
        e_dst = (w >= 0) ? m_fi[w] : 0;
        check("R7/R8 wb_en", wb_en, e_wb);
        check("R8 wb_dst", wb_dst, e_dst);
        // R9: write-back effects
        if (w >= 0) begin
            m_rrs[m_fi[w]] = 0;
            for (int q = 0; q < NF; q++) begin
                if (m_busy[q] != 0 && m_qj[q] == w + 1) begin m_qj[q] = 0; m_rj[q] = 1; end
                if (m_busy[q] != 0 && m_qk[q] == w + 1) begin m_qk[q] = 0; m_rk[q] = 1; end
            end
            m_busy[w] = 0; m_run[w] = 0; m_rj[w] = 0; m_rk[w] = 0;
            m_qj[w] = 0; m_qk[w] = 0;
        end
        for (int i = 0; i < NF; i++)
            if ((e_start >> i) & 1) begin m_rj[i] = 0; m_rk[i] = 0; m_run[i] = 1; m_t0[i] = cyc; end
        if (e_iss != 0) begin
            m_busy[tgt] = 1; m_fi[tgt] = dst; m_fj[tgt] = s1; m_fk[tgt] = s2;
            m_qj[tgt] = m_rrs[s1]; m_qk[tgt] = m_rrs[s2];
            m_rj[tgt] = (m_qj[tgt] == 0); m_rk[tgt] = (m_qk[tgt] == 0);
            m_run[tgt] = 0;
            m_rrs[dst] = tgt + 1;
        end
        iss = (e_iss != 0);
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle(input int n);
        bit d;
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, d);
    endtask

    task automatic issue(input int cls, input int dst, input int s1, input int s2);
        bit got;
        int tries;
        got = 0; tries = 0;
        while (!got && tries < 400) begin
            step(1, cls, dst, s1, s2, got);
            tries++;
        end
        if (!got) check("R1 issue eventually accepted", 0, 1);
    endtask

    task automatic drain();
        int tries, any;
        tries = 0;
        any = 1;
        while (any != 0 && tries < 400) begin
            any = 0;
            for (int i = 0; i < NF; i++) any |= m_busy[i];
            if (any != 0) idle(1);
            tries++;
        end
        check("R9 all units drained", fu_busy, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < NF; i++) begin
            m_busy[i] = 0; m_fi[i] = 0; m_fj[i] = 0; m_fk[i] = 0; m_qj[i] = 0;
            m_qk[i] = 0; m_rj[i] = 0; m_rk[i] = 0; m_run[i] = 0; m_t0[i] = 0;
        end
        for (int r = 0; r < 32; r++) m_rrs[r] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R3: reset state
        check("R3 busy after reset", fu_busy, 0);
        check("R3 start after reset", fu_start, 0);
        check("R3 done after reset", fu_done, 0);
        check("R3 wb after reset", wb_en, 0);
        idle(2);

        // R7: divide r1 <- r2,r3 ; mul r4 <- r1,r2 ; add r2 <- r5,r6 (WAR on r2)
        issue(3, 1, 2, 3);
        issue(1, 4, 1, 2);
        issue(2, 2, 5, 6);
        idle(8);
        check("R7 adder finished", fu_done[3], 1);
        check("R7 adder write held", wb_en[3], 0);
        drain();

        // R1: WAW stall then structural stall
        issue(2, 7, 0, 0);
        begin
            bit g;
            step(1, 0, 7, 1, 1, g);
            check("R1 WAW stall", g, 0);
        end
        drain();
        issue(3, 8, 0, 0);
        begin
            bit g;
            step(1, 3, 9, 0, 0, g);
            check("R1 structural stall", g, 0);
        end
        drain();

        // R2: second multiplier chosen when the first is busy
        issue(1, 10, 0, 0);
        issue(1, 11, 0, 0);
        check("R2 both multipliers busy", fu_busy[2:1], 2'b11);
        drain();

        // R5: consumer issues in the producer's write-back cycle
        issue(0, 9, 0, 0);
        idle(2);
        check("R5 producer writes now", wb_en[0], 1);
        issue(2, 12, 9, 9);
        check("R5 consumer starts next cycle", fu_start[3], 1);
        drain();

        // random traffic with a narrow register range for dense hazards
        for (int n = 0; n < 300; n++) begin
            int c, d, a, b;
            c = int'($urandom_range(3, 0));
            d = int'($urandom_range(7, 0));
            a = int'($urandom_range(7, 0));
            b = int'($urandom_range(7, 0));
            issue(c, d, a, b);
            if ($urandom_range(3, 0) == 0) idle(int'($urandom_range(4, 1)));
        end
        drain();

        summary();
        $finish;
    end
endmodule